// File: doc/BRIEF.md
# Edge Wait Stall Unit

This unit holds an instruction pipeline frozen until one chosen signal makes a chosen transition. An issuing instruction raises a start strobe for one clock. With it come a source number, taken from a register operand or from an immediate field, and a polarity bit that asks for a low-to-high or a high-to-low change. The source number selects one line from a combined space. The external I/O pins come first in that space, and the internal inter-core event lines follow them.

Once started, the unit keeps its stall output high. It compares the selected line with the value it held on the previous clock and waits for the requested transition. A line that already sits at the target level does not end the wait, because a level is not an edge. When the transition arrives the stall drops and a one-clock done pulse is issued. Software that needs both edges issues a rising wait and a falling wait one after the other.

Top module: `edge_wait_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, stall_o and done_o are 0. Asserting reset during a wait abandons it at once.
- R2: A start_i pulse sampled while stall_o is 0 makes stall_o 1 from the next clock.
- R3: Source numbers 0..NPIN-1 select pin_i[n], and NPIN..NPIN+NEVT-1 select evt_i[n-NPIN]. Any larger number that fits the index width reads as a constant 0, so such a wait never ends except by reset.
- R4: When use_imm_i is 1 at start, the source number comes from imm_idx_i. When it is 0, it comes from reg_idx_i. Transitions on the other source have no effect.
- R5: rise_i = 1 requests a 0-to-1 transition, and rise_i = 0 requests a 1-to-0 transition. The opposite transition does not end the wait.
- R6: The value compared against is captured at the start clock. A line already at the target level at start, or one that reached it before start, does not end the wait until it leaves that level and returns.
- R7: If the qualifying transition is first visible at clock edge k, then after edge k stall_o is 0 and done_o is 1, and after edge k+1 done_o is 0 again.
- R8: The source number and polarity are latched at start. Changes on reg_idx_i, imm_idx_i, use_imm_i, rise_i or start_i during a wait have no effect.
- R9: done_o is 1 only in the clock where stall_o has just fallen from 1.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | External pin levels |
| evt_i | input | NEVT | Internal event lines |
| start_i | input | 1 | One-clock request to begin a wait |
| use_imm_i | input | 1 | 1 selects imm_idx_i, 0 selects reg_idx_i |
| reg_idx_i | input | IDX_W | Source number from register operand |
| imm_idx_i | input | IDX_W | Source number from immediate field |
| rise_i | input | 1 | 1 waits for rising edge, 0 for falling |
| stall_o | output | 1 | Pipeline hold while waiting |
| done_o | output | 1 | One-clock pulse when the wait ends |

## Verification
The bench places the line at the target level at start, and also raises it just before start. A design that treated a level as a hit, or that kept a stale previous value, would release at once. It toggles a decoy source, changes the index and polarity inputs mid-wait, and pulses start again during a stall. A design that used the wrong operand or relatched its selection would end the wait early. It also runs a rising wait back-to-back with a falling wait, tries an out-of-range source, and resets during a wait. A missing latch on the start value, a double-length done pulse, or a reset that failed to abandon the wait would each show as a wrong stall or done level on a named clock.

// File: rtl/edge_wait_pkg.sv
package edge_wait_pkg;

    // Polarity encoding shared by the unit and its edge evaluator
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

endpackage

// File: rtl/ewu_src_mux.sv
// Selects one line out of the combined pin / event space.
module ewu_src_mux #(
    parameter int NPIN  = 32,
    parameter int NEVT  = 8,
    parameter int IDX_W = 6
) (
    input  logic [NPIN-1:0]  pin_i,
    input  logic [NEVT-1:0]  evt_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             sel_o
);
    localparam int NSRC = NPIN + NEVT;
    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0] space;

    for (genvar g = 0; g < SPAN; g++) begin : g_space
        if (g < NPIN) begin : g_pin
            assign space[g] = pin_i[g];
        end else if (g < NSRC) begin : g_evt
            assign space[g] = evt_i[g-NPIN];
        end else begin : g_none
            assign space[g] = 1'b0;
        end
    end

    assign sel_o = space[idx_i];

endmodule

// File: rtl/ewu_edge_eval.sv
// Decides whether the step from prev to cur is the requested transition.
module ewu_edge_eval
    import edge_wait_pkg::*;
(
    input  logic      prev_i,
    input  logic      cur_i,
    input  edge_pol_e pol_i,
    output logic      hit_o
);
    always_comb begin
        unique case (pol_i)
            EDGE_RISE: hit_o = ~prev_i &  cur_i;
            default:   hit_o =  prev_i & ~cur_i;
        endcase
    end
endmodule

// File: rtl/edge_wait_unit.sv
module edge_wait_unit
    import edge_wait_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int NEVT  = 8,
    parameter int NSRC  = NPIN + NEVT,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pin_i,
    input  logic [NEVT-1:0]  evt_i,
    input  logic             start_i,
    input  logic             use_imm_i,
    input  logic [IDX_W-1:0] reg_idx_i,
    input  logic [IDX_W-1:0] imm_idx_i,
    input  logic             rise_i,
    output logic             stall_o,
    output logic             done_o
);
    typedef struct packed {
        logic             busy;
        logic             done;
        edge_pol_e        pol;
        logic             prev;
        logic [IDX_W-1:0] src;
    } wait_state_t;

    wait_state_t st_d, st_q;

    logic [IDX_W-1:0] req_idx;
    logic             req_lvl;
    logic             cur_lvl;
    logic             hit;

    assign req_idx = use_imm_i ? imm_idx_i : reg_idx_i;

    // Level of the requested source, used to seed the compare at start
    ewu_src_mux #(.NPIN(NPIN), .NEVT(NEVT), .IDX_W(IDX_W)) u_req_mux (
        .pin_i (pin_i),
        .evt_i (evt_i),
        .idx_i (req_idx),
        .sel_o (req_lvl)
    );

    // Level of the latched source during the wait
    ewu_src_mux #(.NPIN(NPIN), .NEVT(NEVT), .IDX_W(IDX_W)) u_cur_mux (
        .pin_i (pin_i),
        .evt_i (evt_i),
        .idx_i (st_q.src),
        .sel_o (cur_lvl)
    );

    ewu_edge_eval u_eval (
        .prev_i (st_q.prev),
        .cur_i  (cur_lvl),
        .pol_i  (st_q.pol),
        .hit_o  (hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.src  = req_idx;
                st_d.pol  = rise_i ? EDGE_RISE : EDGE_FALL;
                st_d.prev = req_lvl;
            end
        end else if (hit) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.prev = cur_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_o = st_q.busy;
    assign done_o  = st_q.done;

    // R2: an accepted start raises the stall
    a_r2_start_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && start_i) |=> stall_o);

    // R7: a detected transition releases the stall with a done pulse
    a_r7_hit_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && hit) |=> (!stall_o && done_o));

    // R7: the done pulse lasts one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: done only accompanies the falling stall
    a_r9_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(stall_o));

    // R6: without a transition the wait continues
    a_r6_hold_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !hit) |=> stall_o);

    // R8: the latched source does not move during a wait
    a_r8_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |-> ($stable(st_q.src) && $stable(st_q.pol)));

endmodule

// File: tb/tb_edge_wait_unit.sv
`timescale 1ns/1ps
module tb_edge_wait_unit;
    localparam int NPIN  = 32;
    localparam int NEVT  = 8;
    localparam int NSRC  = NPIN + NEVT;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_v = '0;
    logic             start_i = 1'b0;
    logic             use_imm_i = 1'b0;
    logic [IDX_W-1:0] reg_idx_i = '0;
    logic [IDX_W-1:0] imm_idx_i = '0;
    logic             rise_i = 1'b0;
    logic             stall_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    edge_wait_unit #(.NPIN(NPIN), .NEVT(NEVT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (src_v[NPIN-1:0]),
        .evt_i     (src_v[NSRC-1:NPIN]),
        .start_i   (start_i),
        .use_imm_i (use_imm_i),
        .reg_idx_i (reg_idx_i),
        .imm_idx_i (imm_idx_i),
        .rise_i    (rise_i),
        .stall_o   (stall_o),
        .done_o    (done_o)
    );

    typedef struct packed {
        logic [5:0] idx;
        logic       use_imm;
        logic       pol;
        logic       pre;
        logic [3:0] hold;
        logic [5:0] decoy;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{6'd3,  1'b0, 1'b1, 1'b0, 4'd2, 6'd5},
        '{6'd17, 1'b1, 1'b1, 1'b1, 4'd3, 6'd2},
        '{6'd31, 1'b0, 1'b0, 1'b1, 4'd1, 6'd0},
        '{6'd0,  1'b1, 1'b0, 1'b0, 4'd4, 6'd31},
        '{6'd32, 1'b0, 1'b1, 1'b0, 4'd2, 6'd33},
        '{6'd39, 1'b1, 1'b0, 1'b1, 4'd0, 6'd38},
        '{6'd35, 1'b0, 1'b0, 1'b0, 4'd3, 6'd4},
        '{6'd12, 1'b1, 1'b1, 1'b1, 4'd5, 6'd13}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic begin_wait(input logic [5:0] idx, input logic imm,
                              input logic [5:0] other, input logic pol);
        use_imm_i = imm;
        reg_idx_i = imm ? other : idx;
        imm_idx_i = imm ? idx : other;
        rise_i    = pol;
        start_i   = 1'b1;
        tick();
        start_i   = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        src_v = '0;
        src_v[v.idx]   = v.pre;
        src_v[v.decoy] = v.pre;
        tick();
        begin_wait(v.idx, v.use_imm, v.decoy, v.pol);
        chk("R2 stall after start", stall_o, 1'b1);
        chk("R2 no done at start", done_o, 1'b0);
        for (int h = 0; h < int'(v.hold); h++) begin
            src_v[v.decoy] = ~src_v[v.decoy];
            tick();
            chk("R4 decoy source ignored", stall_o, 1'b1);
        end
        if (v.pre == v.pol) begin
            src_v[v.idx] = ~v.pol;
            tick();
            chk("R6 level or wrong edge keeps stall", stall_o, 1'b1);
        end
        src_v[v.idx] = v.pol;
        tick();
        chk("R5 requested edge releases stall", stall_o, 1'b0);
        chk("R7 done pulse on release", done_o, 1'b1);
        tick();
        chk("R7 done lasts one clock", done_o, 1'b0);
        chk("R9 stall stays low", stall_o, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        chk("R1 reset stall", stall_o, 1'b0);
        chk("R1 reset done", done_o, 1'b0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R6: edge just before start is not counted
        src_v = '0;
        tick();
        src_v[8] = 1'b1;
        tick();
        begin_wait(6'd8, 1'b0, 6'd9, 1'b1);
        tick();
        chk("R6 earlier edge not counted", stall_o, 1'b1);
        src_v[8] = 1'b0;
        tick();
        chk("R6 falling on rise wait", stall_o, 1'b1);
        src_v[8] = 1'b1;
        tick();
        chk("R6 fresh rise ends wait", done_o, 1'b1);
        tick();

        // R8: inputs changed mid-wait and a second start are ignored
        src_v = '0;
        begin_wait(6'd9, 1'b0, 6'd10, 1'b1);
        reg_idx_i = 6'd10;
        imm_idx_i = 6'd10;
        use_imm_i = 1'b1;
        rise_i    = 1'b0;
        start_i   = 1'b1;
        src_v[10] = 1'b1;
        tick();
        start_i   = 1'b0;
        chk("R8 restart and new index ignored", stall_o, 1'b1);
        src_v[10] = 1'b0;
        tick();
        chk("R8 new polarity ignored", stall_o, 1'b1);
        src_v[9] = 1'b1;
        tick();
        chk("R8 latched source releases", stall_o, 1'b0);
        chk("R8 done on latched source", done_o, 1'b1);

        // Both edges by alternation, back to back
        src_v = '0;
        begin_wait(6'd20, 1'b1, 6'd0, 1'b1);
        src_v[20] = 1'b1;
        tick();
        chk("R5 rising wait done", done_o, 1'b1);
        begin_wait(6'd20, 1'b1, 6'd0, 1'b0);
        chk("R2 second wait stalls", stall_o, 1'b1);
        chk("R9 no done without release", done_o, 1'b0);
        src_v[20] = 1'b0;
        tick();
        chk("R5 falling wait done", done_o, 1'b1);
        tick();

        // R3: out-of-range source never sees an edge
        src_v = '0;
        begin_wait(6'd50, 1'b0, 6'd1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            src_v = ~src_v;
            tick();
            chk("R3 out-of-range reads low", stall_o, 1'b1);
        end

        // R1: reset abandons the wait
        rst_n = 1'b0;
        #1;
        chk("R1 reset drops stall", stall_o, 1'b0);
        chk("R1 reset no done", done_o, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 stays idle after reset", stall_o, 1'b0);

        // R2 after reset, event line source
        src_v = '0;
        begin_wait(6'd36, 1'b1, 6'd3, 1'b1);
        chk("R2 wait after reset", stall_o, 1'b1);
        src_v[36] = 1'b1;
        tick();
        chk("R3 event line releases", done_o, 1'b1);
        tick();

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule